// File: doc/BRIEF.md
# Vector-to-Scalar Floating-Point Move Bridge

This block sits between the vector unit and the scalar floating-point register file. It has two paths. On the write path, the low element of a vector source register is turned into a scalar register value. An element narrower than the scalar register is wrapped so that every bit above the element is one. An element as wide as the scalar register is copied unchanged. The result and its write strobe are registered, and a one-cycle pulse tells the vector unit to reset its start index.

On the read path, a scalar register value is turned into an operand for vector-scalar instructions. If the bits above the element width are all ones, the low element bits are returned. If not, the canonical quiet NaN of that width is returned. An element width greater than the scalar register width, or the reserved width code, is reported as an illegal configuration. In that case no data is produced and no write is issued.

The scalar register width is the parameter `FLEN`, which may be 16, 32 or 64. The vector element input and the operand output are always 64 bits wide.

Top module: `fpmv_scalar_bridge`

## Requirements
- R1: The width code `sew_i` selects 16 bits (0), 32 bits (1) or 64 bits (2). Code 3 is reserved and always raises `width_err_o`.
- R2: A legal write of a width narrower than `FLEN` sets `fwr_data_o` to the low element bits of `elem0_i`, with every bit from the element width up to `FLEN-1` set to one.
- R3: A legal write of a width equal to `FLEN` sets `fwr_data_o` to the low `FLEN` bits of `elem0_i`, unchanged.
- R4: `fwr_en_o` and `fwr_data_o` update on the clock edge that samples `wr_en_i` high with a legal width. In every other cycle `fwr_en_o` is low and `fwr_data_o` keeps its value.
- R5: Only the low element-width bits of `elem0_i` reach the written value. Bits of `elem0_i` above the element width have no effect.
- R6: On read, when bits from the element width up to `FLEN-1` of `frd_i` are all ones, `operand_o` is the low element bits of `frd_i`, zero-extended to 64 bits. This path is combinational.
- R7: On read, when any of those upper bits is zero, `operand_o` is the canonical quiet NaN for the width, zero-extended: 0x7E00 for 16 bits and 0x7FC00000 for 32 bits.
- R8: On read, a width equal to `FLEN` returns `frd_i` unchanged, zero-extended.
- R9: When the width exceeds `FLEN` or the code is reserved, `width_err_o` is high, `operand_o` is zero and no write is issued.
- R10: `vstart_clr_o` pulses high for exactly the cycle in which a completed write is presented on `fwr_en_o`.
- R11: After reset, `fwr_en_o` and `vstart_clr_o` are low and `fwr_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sew_i | input | 2 | Element width code |
| wr_en_i | input | 1 | Request to move element 0 into the scalar register |
| elem0_i | input | 64 | Element 0 of the source vector register |
| frd_i | input | FLEN | Scalar FP register read data |
| fwr_en_o | output | 1 | Registered scalar write strobe |
| fwr_data_o | output | FLEN | Registered boxed write data |
| vstart_clr_o | output | 1 | Pulse that clears the vector start index |
| operand_o | output | 64 | Unboxed scalar operand, zero-extended |
| width_err_o | output | 1 | Illegal width configuration |

## Verification
The hardest case to reach is a read operand whose upper bits are almost all ones with exactly one zero. Uniform random scalar data nearly always fails the box check outright. The stimulus therefore builds properly boxed words and clears one chosen high bit in some of them, alongside fully random words, so the canonical-NaN path is tested at the boundary. The "element wider than the scalar register" error cannot occur with a 64-bit scalar register. A second instance with a 32-bit scalar register receives the same stimulus so that this error is exercised alongside the reserved code.

// File: rtl/fpmv_pkg.sv
package fpmv_pkg;
  localparam int ELEN  = 64;
  localparam int NUM_W = 3;

  typedef enum logic [1:0] {
    SEW_E16  = 2'd0,
    SEW_E32  = 2'd1,
    SEW_E64  = 2'd2,
    SEW_RSVD = 2'd3
  } sew_code_t;

  function automatic int sew_width(logic [1:0] code);
    if (code == SEW_RSVD) return 0;
    return 16 << code;
  endfunction

  function automatic logic [ELEN-1:0] canon_nan(int w);
    case (w)
      16:      return 64'h0000_0000_0000_7E00;
      32:      return 64'h0000_0000_7FC0_0000;
      default: return 64'h7FF8_0000_0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/fpmv_width_chk.sv
module fpmv_width_chk
  import fpmv_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [1:0] sew_i,
  output logic       illegal_o
);
  always_comb begin
    illegal_o = (sew_i == SEW_RSVD) || (sew_width(sew_i) > FLEN);
  end
endmodule

// File: rtl/fpmv_box.sv
module fpmv_box
  import fpmv_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [1:0]      sew_i,
  input  logic [ELEN-1:0] elem_i,
  output logic [FLEN-1:0] boxed_o
);
  for (genvar gi = 0; gi < NUM_W; gi++) begin : g_w
    localparam int W = 16 << gi;
    logic [FLEN-1:0] val;
    if (W < FLEN) begin : g_narrow
      assign val = {{(FLEN-W){1'b1}}, elem_i[W-1:0]};
    end else if (W == FLEN) begin : g_full
      assign val = elem_i[FLEN-1:0];
    end else begin : g_wide
      assign val = '0;
    end
  end

  always_comb begin
    case (sew_i)
      SEW_E16: boxed_o = g_w[0].val;
      SEW_E32: boxed_o = g_w[1].val;
      SEW_E64: boxed_o = g_w[2].val;
      default: boxed_o = '0;
    endcase
  end
endmodule

// File: rtl/fpmv_unbox.sv
module fpmv_unbox
  import fpmv_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [1:0]      sew_i,
  input  logic [FLEN-1:0] frd_i,
  output logic [ELEN-1:0] operand_o
);
  for (genvar gi = 0; gi < NUM_W; gi++) begin : g_w
    localparam int W = 16 << gi;
    logic [ELEN-1:0] val;
    if (W < FLEN) begin : g_narrow
      always_comb begin
        val = '0;
        if (&frd_i[FLEN-1:W]) val[W-1:0] = frd_i[W-1:0];
        else                  val = canon_nan(W);
      end
    end else if (W == FLEN) begin : g_full
      always_comb begin
        val = '0;
        val[W-1:0] = frd_i;
      end
    end else begin : g_wide
      assign val = '0;
    end
  end

  always_comb begin
    case (sew_i)
      SEW_E16: operand_o = g_w[0].val;
      SEW_E32: operand_o = g_w[1].val;
      SEW_E64: operand_o = g_w[2].val;
      default: operand_o = '0;
    endcase
  end
endmodule

// File: rtl/fpmv_scalar_bridge.sv
module fpmv_scalar_bridge
  import fpmv_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      sew_i,
  input  logic            wr_en_i,
  input  logic [63:0]     elem0_i,
  input  logic [FLEN-1:0] frd_i,
  output logic            fwr_en_o,
  output logic [FLEN-1:0] fwr_data_o,
  output logic            vstart_clr_o,
  output logic [63:0]     operand_o,
  output logic            width_err_o
);
  logic            illegal;
  logic [FLEN-1:0] boxed;
  logic [ELEN-1:0] unboxed;
  logic            wr_go;
  logic            en_d, en_q;
  logic [FLEN-1:0] data_d, data_q;

  fpmv_width_chk #(.FLEN(FLEN)) u_wchk (
    .sew_i     (sew_i),
    .illegal_o (illegal)
  );

  fpmv_box #(.FLEN(FLEN)) u_box (
    .sew_i   (sew_i),
    .elem_i  (elem0_i),
    .boxed_o (boxed)
  );

  fpmv_unbox #(.FLEN(FLEN)) u_unbox (
    .sew_i     (sew_i),
    .frd_i     (frd_i),
    .operand_o (unboxed)
  );

  always_comb begin
    wr_go  = wr_en_i && !illegal;
    en_d   = wr_go;
    data_d = wr_go ? boxed : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      data_q <= '0;
    end else begin
      en_q <= en_d;
      if (wr_go) data_q <= data_d;
    end
  end

  assign fwr_en_o     = en_q;
  assign vstart_clr_o = en_q;
  assign fwr_data_o   = data_q;
  assign operand_o    = illegal ? '0 : unboxed;
  assign width_err_o  = illegal;
endmodule

// File: rtl/fpmv_chk.sv
module fpmv_chk #(
  parameter int FLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      sew_i,
  input logic            wr_en_i,
  input logic [63:0]     elem0_i,
  input logic            fwr_en_o,
  input logic [FLEN-1:0] fwr_data_o,
  input logic            vstart_clr_o,
  input logic [63:0]     operand_o,
  input logic            width_err_o
);
  AST_RSVD_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sew_i == 2'd3 |-> width_err_o); // R1
  AST_WR_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !width_err_o |=> fwr_en_o); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && !width_err_o) |=> $stable(fwr_data_o)); // R4
  AST_LOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !width_err_o |=> fwr_data_o[15:0] == $past(elem0_i[15:0])); // R5
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    width_err_o |=> !fwr_en_o); // R9
  AST_ERR_ZERO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    width_err_o |-> operand_o == 64'd0); // R9
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !width_err_o |=> vstart_clr_o); // R10
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> !vstart_clr_o); // R10
  if (FLEN > 16) begin : g_box16
    AST_E16_BOXED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && sew_i == 2'd0 |=> &fwr_data_o[FLEN-1:16]); // R2
  end
endmodule

bind fpmv_scalar_bridge fpmv_chk #(.FLEN(FLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sew_i        (sew_i),
  .wr_en_i      (wr_en_i),
  .elem0_i      (elem0_i),
  .fwr_en_o     (fwr_en_o),
  .fwr_data_o   (fwr_data_o),
  .vstart_clr_o (vstart_clr_o),
  .operand_o    (operand_o),
  .width_err_o  (width_err_o)
);

// File: tb/sim_fpmv_scalar_bridge.sv
`timescale 1ns/1ps
module sim_fpmv_scalar_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sew = 2'd0;
  logic        wr_en = 1'b0;
  logic [63:0] elem = 64'd0;
  logic [63:0] frd0 = 64'd0;
  logic [31:0] frd1 = 32'd0;

  logic        en0, clr0, err0, en1, clr1, err1;
  logic [63:0] dat0, op0, op1;
  logic [31:0] dat1;

  int checks = 0;
  int fails  = 0;
  logic [63:0] pd0 = 64'd0;
  logic [63:0] pd1 = 64'd0;

  always #4 clk = ~clk;

  fpmv_scalar_bridge #(.FLEN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .sew_i(sew), .wr_en_i(wr_en), .elem0_i(elem),
    .frd_i(frd0), .fwr_en_o(en0), .fwr_data_o(dat0), .vstart_clr_o(clr0),
    .operand_o(op0), .width_err_o(err0));

  fpmv_scalar_bridge #(.FLEN(32)) u1 (
    .clk(clk), .rst_n(rst_n), .sew_i(sew), .wr_en_i(wr_en), .elem0_i(elem),
    .frd_i(frd1), .fwr_en_o(en1), .fwr_data_o(dat1), .vstart_clr_o(clr1),
    .operand_o(op1), .width_err_o(err1));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wid(logic [1:0] s);
    return (s == 2'd3) ? 0 : (16 << s);
  endfunction

  function automatic logic e_err(int fl, logic [1:0] s);
    return (s == 2'd3) || (wid(s) > fl);
  endfunction

  function automatic logic [63:0] e_box(int fl, logic [1:0] s, logic [63:0] e);
    logic [63:0] r = 64'd0;
    int w = wid(s);
    for (int b = 0; b < 64; b++) r[b] = (b < w) ? e[b] : (b < fl);
    return r;
  endfunction

  function automatic logic e_boxed_ok(int fl, logic [1:0] s, logic [63:0] f);
    for (int b = wid(s); b < fl; b++) if (!f[b]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [63:0] e_rd(int fl, logic [1:0] s, logic [63:0] f);
    logic [63:0] r = 64'd0;
    int w = wid(s);
    if (e_err(fl, s)) return 64'd0;
    if (!e_boxed_ok(fl, s, f)) return (w == 16) ? 64'h7E00 : 64'h7FC0_0000;
    for (int b = 0; b < w; b++) r[b] = f[b];
    return r;
  endfunction

  function automatic string rd_tag(int fl, logic [1:0] s, logic [63:0] f);
    if (e_err(fl, s)) return "R9 operand";
    if (wid(s) == fl) return "R8 operand";
    return e_boxed_ok(fl, s, f) ? "R6 operand" : "R7 operand";
  endfunction

  task automatic apply(logic [1:0] s, logic we, logic [63:0] e, logic [63:0] f);
    logic g0, g1;
    @(negedge clk);
    sew = s; wr_en = we; elem = e; frd0 = f; frd1 = f[31:0];
    #1;
    chk(s == 2'd3 ? "R1 err u0" : "R9 err u0", {63'd0, err0}, {63'd0, e_err(64, s)});
    chk(s == 2'd3 ? "R1 err u1" : "R9 err u1", {63'd0, err1}, {63'd0, e_err(32, s)});
    chk(rd_tag(64, s, f), op0, e_rd(64, s, f));
    chk(rd_tag(32, s, {32'd0, f[31:0]}), op1, e_rd(32, s, {32'd0, f[31:0]}));
    g0 = we && !e_err(64, s);
    g1 = we && !e_err(32, s);
    if (g0) pd0 = e_box(64, s, e);
    if (g1) pd1 = e_box(32, s, e);
    @(posedge clk); #1;
    chk("R4 wr en u0", {63'd0, en0}, {63'd0, g0});
    chk("R4 wr en u1", {63'd0, en1}, {63'd0, g1});
    chk("R10 vstart clr u0", {63'd0, clr0}, {63'd0, g0});
    chk("R10 vstart clr u1", {63'd0, clr1}, {63'd0, g1});
    chk(wid(s) < 64 ? "R2 data u0" : "R3 data u0", dat0, pd0);
    chk(wid(s) < 32 ? "R2 data u1" : "R3 data u1", {32'd0, dat1}, pd1);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0]  s;
    logic [63:0] e, f;
    void'($urandom(32'd1234));
    #20;
    // R11 reset state
    chk("R11 en", {62'd0, en0, en1}, 64'd0);
    chk("R11 clr", {62'd0, clr0, clr1}, 64'd0);
    chk("R11 data", dat0 | {32'd0, dat1}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    apply(2'd0, 1'b1, 64'hDEAD_BEEF_CAFE_1234, 64'hFFFF_FFFF_FFFF_3C00);
    chk("R5 upper elem ignored", dat0, 64'hFFFF_FFFF_FFFF_1234);
    apply(2'd0, 1'b0, 64'h0, 64'h7FFF_FFFF_FFFF_3C00);
    apply(2'd1, 1'b1, 64'h1111_2222_3F80_0000, 64'hFFFF_FFFF_4049_0FDB);
    chk("R5 upper elem ignored e32", dat0, 64'hFFFF_FFFF_3F80_0000);
    apply(2'd1, 1'b0, 64'h0, 64'hFFFF_FFFE_4049_0FDB);
    apply(2'd2, 1'b1, 64'h4009_21FB_5444_2D18, 64'h0123_4567_89AB_CDEF);
    apply(2'd3, 1'b1, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    apply(2'd2, 1'b0, 64'h5555_5555_5555_5555, 64'h0);
    apply(2'd0, 1'b1, 64'h0, 64'hFFFF_FFFF_0000_0001);

    for (int i = 0; i < 400; i++) begin
      s = 2'($urandom_range(0, 3));
      e = {$urandom(), $urandom()};
      case ($urandom_range(0, 2))
        0: f = {$urandom(), $urandom()};
        1: f = e_box(64, s, {$urandom(), $urandom()});
        default: begin
          f = e_box(64, s, {$urandom(), $urandom()});
          f[$urandom_range(wid(s) == 0 ? 16 : wid(s), 63)] = 1'b0;
        end
      endcase
      if ($urandom_range(0, 1) == 1) f[63:32] = 32'hFFFF_FFFF;
      apply(s, 1'($urandom_range(0, 1)), e, f);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule